// File: doc/BRIEF.md
# Idle Standby Timer Bank with SMI Status

This block keeps watch over six peripherals (a disk controller, an audio function, a serial port and three generic devices) and tells the system when one of them has sat unused for too long. Each device owns an 8-bit down-counter. The counters step once per coarse tick of about eight seconds, which a prescaler derives from the system clock. An access strobe from the device's address decoder reloads that device's counter with its programmed value, so only a full quiet interval lets the count reach zero.

When an enabled counter runs out, the block latches a sticky status bit for that device. A system management interrupt request is raised while any status bit is set and the global interrupt enable is on. Firmware talks to the block through a byte-wide register port. It programs the reload values, the per-device enables, the global enable and a freeze control, and it acknowledges events by writing zeros into the status byte.

Top module: `idle_tmr_bank`

## Requirements
- R1: After reset every register reads 00h and `smi_req` is low.
- R2: The per-device enable byte sits at B0h (bits 5:0). The control byte sits at B1h, with bit 0 as the global interrupt enable and bit 1 as freeze. The reload bytes are at B4h for IDE, B5h for audio, B6h for COM, B7h for device 3, B8h for device 2 and B9h for device 1. All of these read back what was written. Unimplemented bits and addresses read 0.
- R3: The status byte at B2h maps bit 5 to IDE, bit 4 to audio, bit 3 to COM, bit 2 to device 3, bit 1 to device 2 and bit 0 to device 1. Bits 7:6 always read 0.
- R4: The tick fires once every PRESCALE clocks. A counter reloaded with N expires on the N-th tick after the reload, and its status bit reads 1 from the following cycle.
- R5: An access strobe (`dev_access` bit i, using the same index as status bit i) reloads the counter of an enabled device. Accesses that come faster than the reload interval keep its status bit at 0.
- R6: A device whose enable bit is 0 neither reloads nor counts, and it never sets its status bit.
- R7: Writing 0 to a status bit clears it. Writing 1 leaves it as it was.
- R8: When an expiry and a clearing write to the same status bit fall in the same cycle, the bit ends up as 1.
- R9: `smi_req` is high exactly when the global enable is 1 and at least one status bit is 1.
- R10: While freeze is 1, no counter decrements and no status bit is set. Counting resumes once freeze returns to 0.
- R11: A reload value of 00h keeps the device's counter from ever expiring.
- R12: After expiry a counter stays at zero. Its status bit, once cleared, stays 0 until the device is accessed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe for one cycle |
| reg_addr | input | 8 | Register byte address for both write and read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| dev_access | input | 6 | One-cycle access strobes, bit i for status bit i |
| smi_req | output | 1 | System management interrupt request |

## Verification
The assertions take for granted that writes and access strobes are clean, synchronous single-cycle pulses, and that a status write carries its full clear mask in that one cycle. They also assume the prescale value is larger than one, so ticks never come back to back. The stimulus drives every input at the falling edge and holds each strobe for exactly one rising edge. It places accesses and clearing writes at chosen offsets from a tick, counted from the known reset phase of the prescaler, so the expiry edge and the same-cycle collision land where intended.

// File: rtl/idle_tmr_pkg.sv
package idle_tmr_pkg;

    localparam int unsigned NUM_TMR = 6;
    localparam int unsigned REG_W   = 8;

    localparam logic [REG_W-1:0] ADDR_IEN     = 8'hB0;
    localparam logic [REG_W-1:0] ADDR_CTL     = 8'hB1;
    localparam logic [REG_W-1:0] ADDR_STS     = 8'hB2;
    // Reload byte of the highest index (IDE); lower indices follow upward.
    localparam logic [REG_W-1:0] ADDR_RLD_TOP = 8'hB4;

    typedef enum logic [2:0] {
        TMR_DEV1 = 3'd0,
        TMR_DEV2 = 3'd1,
        TMR_DEV3 = 3'd2,
        TMR_COM  = 3'd3,
        TMR_AUD  = 3'd4,
        TMR_IDE  = 3'd5
    } tmr_id_e;

    typedef struct packed {
        logic [NUM_TMR-1:0] ien;
        logic               frz;
        logic               gen;
        logic [NUM_TMR-1:0] sts;
    } ctl_state_t;

    function automatic logic [REG_W-1:0] rld_addr(input int unsigned idx);
        return ADDR_RLD_TOP + REG_W'(NUM_TMR - 1 - idx);
    endfunction

endpackage

// File: rtl/idle_tick_gen.sv
module idle_tick_gen #(
    parameter int unsigned PRESCALE = 1_600_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PRE_W-1:0] LAST = PRE_W'(PRESCALE - 1);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = (st_q.cnt == LAST);

endmodule

// File: rtl/idle_down_ctr.sv
module idle_down_ctr #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             freeze,
    input  logic             enable,
    input  logic             access,
    input  logic [CNT_W-1:0] rld_val,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_state_t;

    ctr_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (enable && access) begin
            // Reload has priority over a tick in the same cycle.
            st_d.cnt = rld_val;
        end else if (enable && tick && !freeze && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - 1'b1;
            expire   = (st_q.cnt == ONE);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/idle_reg_file.sv
module idle_reg_file
    import idle_tmr_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           reg_wr,
    input  logic [REG_W-1:0]               reg_addr,
    input  logic [REG_W-1:0]               reg_wdata,
    input  logic [NUM_TMR-1:0]             hw_set,
    output logic [REG_W-1:0]               reg_rdata,
    output logic [NUM_TMR-1:0]             ien,
    output logic                           gen,
    output logic                           frz,
    output logic [NUM_TMR-1:0]             sts,
    output logic [NUM_TMR-1:0][REG_W-1:0]  rld
);
    ctl_state_t                     st_d, st_q;
    logic [NUM_TMR-1:0][REG_W-1:0]  rld_d, rld_q;
    logic [NUM_TMR-1:0]             clr_mask;

    always_comb begin
        st_d  = st_q;
        rld_d = rld_q;
        clr_mask = '0;
        if (reg_wr) begin
            if (reg_addr == ADDR_IEN) begin
                st_d.ien = reg_wdata[NUM_TMR-1:0];
            end
            if (reg_addr == ADDR_CTL) begin
                st_d.gen = reg_wdata[0];
                st_d.frz = reg_wdata[1];
            end
            if (reg_addr == ADDR_STS) begin
                clr_mask = ~reg_wdata[NUM_TMR-1:0];
            end
            for (int i = 0; i < NUM_TMR; i++) begin
                if (reg_addr == rld_addr(i)) begin
                    rld_d[i] = reg_wdata;
                end
            end
        end
        // Hardware set is applied after the clear so it wins a collision.
        st_d.sts = (st_q.sts & ~clr_mask) | hw_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= '0;
            rld_q <= '0;
        end else begin
            st_q  <= st_d;
            rld_q <= rld_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_IEN) begin
            reg_rdata[NUM_TMR-1:0] = st_q.ien;
        end
        if (reg_addr == ADDR_CTL) begin
            reg_rdata[1:0] = {st_q.frz, st_q.gen};
        end
        if (reg_addr == ADDR_STS) begin
            reg_rdata[NUM_TMR-1:0] = st_q.sts;
        end
        for (int i = 0; i < NUM_TMR; i++) begin
            if (reg_addr == rld_addr(i)) begin
                reg_rdata = rld_q[i];
            end
        end
    end

    assign ien = st_q.ien;
    assign gen = st_q.gen;
    assign frz = st_q.frz;
    assign sts = st_q.sts;
    assign rld = rld_q;

endmodule

// File: rtl/idle_tmr_bank.sv
module idle_tmr_bank
    import idle_tmr_pkg::*;
#(
    parameter int unsigned PRESCALE = 1_600_000_000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [REG_W-1:0]   reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic [NUM_TMR-1:0] dev_access,
    output logic               smi_req
);
    logic                           tick;
    logic [NUM_TMR-1:0]             ien;
    logic                           gen;
    logic                           frz;
    logic [NUM_TMR-1:0]             sts;
    logic [NUM_TMR-1:0]             expire;
    logic [NUM_TMR-1:0][REG_W-1:0]  rld;

    idle_tick_gen #(
        .PRESCALE (PRESCALE)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    idle_reg_file u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .hw_set    (expire),
        .reg_rdata (reg_rdata),
        .ien       (ien),
        .gen       (gen),
        .frz       (frz),
        .sts       (sts),
        .rld       (rld)
    );

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
        idle_down_ctr #(
            .CNT_W (REG_W)
        ) u_ctr (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .freeze  (frz),
            .enable  (ien[g]),
            .access  (dev_access[g]),
            .rld_val (rld[g]),
            .expire  (expire[g])
        );
    end

    assign smi_req = gen && (|sts);

endmodule

// File: rtl/idle_tmr_bank_chk.sv
module idle_tmr_bank_chk
    import idle_tmr_pkg::*;
#(
    parameter int unsigned PRESCALE = 8
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           reg_wr,
    input logic [REG_W-1:0]               reg_addr,
    input logic                           tick,
    input logic                           frz,
    input logic                           gen,
    input logic [NUM_TMR-1:0]             ien,
    input logic [NUM_TMR-1:0]             sts,
    input logic [NUM_TMR-1:0]             expire,
    input logic [NUM_TMR-1:0][REG_W-1:0]  rld,
    input logic                           smi_req
);
    // Status bits never fall without a status write.
    assert_sts_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && (reg_addr == ADDR_STS)) |=> ((sts & $past(sts)) == $past(sts)));

    // An expiry coinciding with a clearing write still leaves the bit set.
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == ADDR_STS) && (expire != '0))
            |=> ((sts & $past(expire)) == $past(expire)));

    // A newly set status bit belongs to an enabled device.
    assert_set_needs_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((sts & ~$past(sts) & ~$past(ien)) == '0));

    assert_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        frz |-> (expire == '0));

    assert_smi_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !gen |-> !smi_req);

    if (PRESCALE > 1) begin : g_gap
        assert_tick_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
    end

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_zero
        assert_zero_rld_R11: assert property (@(posedge clk) disable iff (!rst_n)
            expire[g] |-> (rld[g] != '0));
    end

endmodule

bind idle_tmr_bank idle_tmr_bank_chk #(
    .PRESCALE (PRESCALE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .tick     (tick),
    .frz      (frz),
    .gen      (gen),
    .ien      (ien),
    .sts      (sts),
    .expire   (expire),
    .rld      (rld),
    .smi_req  (smi_req)
);

// File: tb/sim_idle_tmr_bank.sv
`timescale 1ns/1ps
module sim_idle_tmr_bank;
    import idle_tmr_pkg::*;

    localparam int unsigned P = 8;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               reg_wr = 1'b0;
    logic [7:0]         drv_addr = 8'h00;
    logic [7:0]         mon_addr = 8'h00;
    logic               mon_active = 1'b0;
    logic [7:0]         reg_addr;
    logic [7:0]         reg_wdata = 8'h00;
    logic [7:0]         reg_rdata;
    logic [5:0]         dev_access = '0;
    logic               smi_req;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        bit         is_smi;
        logic [7:0] addr;
        logic [7:0] exp;
        string      tag;
    } sb_item_t;

    sb_item_t sb[$];
    bit busy = 1'b0;

    assign reg_addr = mon_active ? mon_addr : drv_addr;

    always #2.5 clk = ~clk;

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    idle_tmr_bank #(.PRESCALE(P)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .dev_access (dev_access),
        .smi_req    (smi_req)
    );

    // Monitor: evaluates one queued expectation at the next falling edge.
    initial forever begin
        @(negedge clk);
        if (sb.size() > 0) begin
            sb_item_t it;
            logic [7:0] act;
            it = sb.pop_front();
            busy = 1'b1;
            mon_addr = it.addr;
            mon_active = !it.is_smi;
            #1;
            act = it.is_smi ? {7'b0, smi_req} : reg_rdata;
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.addr, act, it.exp);
            end
            mon_active = 1'b0;
            busy = 1'b0;
        end
    end

    task automatic push_chk(input bit is_smi, input logic [7:0] addr,
                            input logic [7:0] exp, input string tag);
        sb_item_t it;
        it.is_smi = is_smi;
        it.addr = addr;
        it.exp = exp;
        it.tag = tag;
        sb.push_back(it);
        wait (sb.size() == 0 && !busy);
    endtask

    task automatic chk_reg(input logic [7:0] addr, input logic [7:0] exp, input string tag);
        push_chk(1'b0, addr, exp, tag);
    endtask

    task automatic chk_smi(input logic exp, input string tag);
        push_chk(1'b1, 8'h00, {7'b0, exp}, tag);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] addr, input logic [7:0] data);
        @(negedge clk);
        reg_wr = 1'b1;
        drv_addr = addr;
        reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic hit(input logic [5:0] mask);
        dev_access = mask;
        @(negedge clk);
        dev_access = '0;
    endtask

    // Land on the falling edge right after a tick edge.
    task automatic sync_after_tick();
        do @(negedge clk); while ((cyc % P) != 0);
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;

        // R1: reset values
        chk_reg(ADDR_IEN, 8'h00, "R1");
        chk_reg(ADDR_CTL, 8'h00, "R1");
        chk_reg(ADDR_STS, 8'h00, "R1");
        chk_reg(8'hB4, 8'h00, "R1");
        chk_smi(1'b0, "R1");

        // R2: register map readback and masking
        wr(ADDR_IEN, 8'hFF);
        chk_reg(ADDR_IEN, 8'h3F, "R2");
        wr(ADDR_CTL, 8'hFF);
        chk_reg(ADDR_CTL, 8'h03, "R2");
        for (int i = 0; i < 6; i++) wr(8'hB4 + 8'(i), 8'h11 * 8'(i + 1));
        for (int i = 0; i < 6; i++) chk_reg(8'hB4 + 8'(i), 8'h11 * 8'(i + 1), "R2");
        chk_reg(8'hB3, 8'h00, "R2");
        wr(ADDR_CTL, 8'h01);
        wr(ADDR_IEN, 8'h3E);

        // R4: IDE (status bit 5) reloaded with 3 expires on the third tick
        wr(8'hB4, 8'h03);
        sync_after_tick();
        hit(6'b100000);
        idle(3 * P - 3);
        chk_reg(ADDR_STS, 8'h00, "R4");
        chk_reg(ADDR_STS, 8'h20, "R4");

        // R5: audio (bit 4) kept alive by frequent accesses, then expires
        wr(8'hB5, 8'h02);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            hit(6'b010000);
            idle(P - 2);
        end
        chk_reg(ADDR_STS, 8'h20, "R5");
        idle(3 * P);
        chk_reg(ADDR_STS, 8'h30, "R5");

        // R9: interrupt follows status and global enable
        chk_smi(1'b1, "R9");
        wr(ADDR_CTL, 8'h00);
        chk_smi(1'b0, "R9");
        wr(ADDR_CTL, 8'h01);

        // R7: write-zero clears, write-one keeps
        wr(ADDR_STS, 8'hEF);
        chk_reg(ADDR_STS, 8'h20, "R7");
        wr(ADDR_STS, 8'hFF);
        chk_reg(ADDR_STS, 8'h20, "R7");

        // R12: expired audio timer does not fire again without an access
        idle(4 * P);
        chk_reg(ADDR_STS, 8'h20, "R12");
        wr(ADDR_STS, 8'h00);
        chk_reg(ADDR_STS, 8'h00, "R7");
        chk_smi(1'b0, "R9");

        // R10: freeze holds the COM timer (bit 3)
        wr(8'hB6, 8'h02);
        sync_after_tick();
        hit(6'b001000);
        wr(ADDR_CTL, 8'h03);
        idle(5 * P);
        chk_reg(ADDR_STS, 8'h00, "R10");
        wr(ADDR_CTL, 8'h01);
        idle(3 * P);
        chk_reg(ADDR_STS, 8'h08, "R10");
        wr(ADDR_STS, 8'h00);

        // R11: reload of 00h on device 2 (bit 1) never expires
        wr(8'hB8, 8'h00);
        @(negedge clk);
        hit(6'b000010);
        idle(4 * P);
        chk_reg(ADDR_STS, 8'h00, "R11");

        // R6: device 1 (bit 0) is disabled, access and wait do nothing
        wr(8'hB9, 8'h01);
        @(negedge clk);
        hit(6'b000001);
        idle(3 * P);
        chk_reg(ADDR_STS, 8'h00, "R6");

        // R8: device 3 (bit 2) expires in the same cycle as a clearing write
        wr(8'hB7, 8'h01);
        sync_after_tick();
        hit(6'b000100);
        idle(P - 2);
        reg_wr = 1'b1;
        drv_addr = ADDR_STS;
        reg_wdata = 8'h00;
        @(negedge clk);
        reg_wr = 1'b0;
        chk_reg(ADDR_STS, 8'h04, "R8");
        chk_reg(ADDR_STS, 8'h04, "R3");
        chk_smi(1'b1, "R9");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(5 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule